// File: doc/BRIEF.md
# Program Fetch Routing Decoder

This block sits beside a processor's fetch unit. For each program-fetch address on a 16-bit bus it decides whether on-chip ROM answers the fetch or the external memory bus does. It drives a ROM select, an external-fetch flag and an active-low program-store enable strobe that the external memory uses as its chip or output enable. The decision is combinational from three things: the fetch address, a 3-bit size code held in a register, and an external-access pin.

The size code sets how much of the low address space the on-chip ROM covers, from none up to 16KB. Every address at or above that limit is sent off-chip. Driving the external-access pin low sends every fetch off-chip, whatever the code says. Software can only rewrite the code after a timed-access unlock sequence. The register comes out of reset at the 16KB setting, so a system that never uses the feature needs no set-up.

Register writes arrive on a single write port. A select bit picks either the timed-access key register or the size register, and the data travels on an 8-bit bus.

Top module: `progfetch_router`

## Requirements
- R1: After a synchronous active-high reset the size code is 101 (16KB). Address 3FFFh is then served on-chip and 4000h externally.
- R2: The code gives the on-chip limit as follows: 000 = 0, 001 = 1024, 010 = 2048, 011 = 4096, 100 = 8192, 101 = 16384 bytes. A valid fetch with the pin high is on-chip when its address is below the limit, and external when it is at or above the limit.
- R3: While the external-access pin (ext_access_n) is 0, every valid fetch is external, whatever the code.
- R4: pstore_n is low only during a valid external fetch. rom_sel and ext_fetch are never high together, and both are low while fetch_valid is 0.
- R5: A write to the size register (wr_sel = 1, code in data bits [2:0]) outside an open unlock window leaves the code unchanged.
- R6: The unlock sequence is two writes to the key register (wr_sel = 0): first AAh, then 55h no later than 3 cycles after it. This opens a window in which a size write is accepted on any of the 4 cycles that follow the 55h write. A size write in the 5th cycle is ignored, and so is one that follows a 55h write arriving too late.
- R7: A size write carrying a reserved code (110 or 111) is ignored, and the previous code is kept.
- R8: An accepted size write changes the routing from the fetch in the cycle right after the write.
- R9: Each unlock admits one size write. A second size write in the same window is ignored.
- R10: Reset closes an open unlock window, so a size write after reset without a new unlock is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A program fetch is presented this cycle |
| fetch_addr | input | 16 | Program-fetch address |
| ext_access_n | input | 1 | External-access pin; 0 forces every fetch off-chip |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = timed-access key register, 1 = size register |
| wr_data | input | 8 | Write data; size code in bits [2:0] |
| rom_sel | output | 1 | Fetch served by on-chip ROM |
| ext_fetch | output | 1 | Fetch served by the external bus |
| pstore_n | output | 1 | Active-low program-store enable for external memory |

## Verification
For every valid code, the routing is probed at the last on-chip address and the first external address, and also at 0000h and FFFFh. Each probe is made with the pin at both levels, which separates an off-by-one in the limit compare and a wrong shift in the code-to-limit mapping from a missing pin override. The unlock sequence is exercised with size writes placed just inside and just outside the 4-cycle window, with a late second key write, with a repeated write in one window, with reserved codes and with a reset in the middle of a window. Each of these patterns shows up as a routing change, or the lack of one, at the next fetch. Fetches with fetch_valid low confirm that the strobe and both selects stay idle.

// File: rtl/progfetch_pkg.sv
package progfetch_pkg;

    localparam int ADDR_W     = 16;
    localparam int CODE_W     = 3;
    localparam int BASE_SHIFT = 9;
    localparam int CODE_MAX   = 5;
    localparam logic [CODE_W-1:0] RESET_CODE = 3'b101;

    typedef enum logic [1:0] {
        TA_IDLE  = 2'd0,
        TA_ARMED = 2'd1,
        TA_OPEN  = 2'd2
    } ta_state_t;

    typedef struct packed {
        logic en;
        logic sel;
        logic [7:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic rom;
        logic ext;
    } route_t;

    function automatic logic code_valid(input logic [CODE_W-1:0] c);
        return int'(c) <= CODE_MAX;
    endfunction

    function automatic logic [ADDR_W:0] code_limit(input logic [CODE_W-1:0] c);
        logic [ADDR_W:0] lim;
        if (c == '0) lim = '0;
        else         lim = (ADDR_W+1)'(1) << (BASE_SHIFT + int'(c));
        return lim;
    endfunction

endpackage

// File: rtl/ta_unlock.sv
module ta_unlock
    import progfetch_pkg::*;
#(
    parameter logic [7:0] KEY_FIRST  = 8'hAA,
    parameter logic [7:0] KEY_SECOND = 8'h55,
    parameter int ARM_CYC = 3,
    parameter int WIN_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       consume,
    output logic       win_open
);
    localparam int ARM_W = $clog2(ARM_CYC + 1);
    localparam int WIN_W = $clog2(WIN_CYC + 1);

    ta_state_t        state;
    logic [ARM_W-1:0] arm_cnt;
    logic [WIN_W-1:0] win_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TA_IDLE;
            arm_cnt <= '0;
            win_cnt <= '0;
        end else begin
            case (state)
                TA_IDLE: begin
                    if (key_wr && key_data == KEY_FIRST) begin
                        state   <= TA_ARMED;
                        arm_cnt <= ARM_W'(ARM_CYC);
                    end
                end
                TA_ARMED: begin
                    if (key_wr) begin
                        if (key_data == KEY_SECOND) begin
                            state   <= TA_OPEN;
                            win_cnt <= WIN_W'(WIN_CYC);
                        end else if (key_data == KEY_FIRST) begin
                            arm_cnt <= ARM_W'(ARM_CYC);
                        end else begin
                            state <= TA_IDLE;
                        end
                    end else if (arm_cnt == ARM_W'(1)) begin
                        state <= TA_IDLE;
                    end else begin
                        arm_cnt <= arm_cnt - ARM_W'(1);
                    end
                end
                TA_OPEN: begin
                    if (consume || win_cnt == WIN_W'(1)) begin
                        state   <= TA_IDLE;
                        win_cnt <= '0;
                    end else begin
                        win_cnt <= win_cnt - WIN_W'(1);
                    end
                end
                default: state <= TA_IDLE;
            endcase
        end
    end

    assign win_open = (state == TA_OPEN);

endmodule

// File: rtl/size_reg.sv
module size_reg
    import progfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    output logic [CODE_W-1:0] code
);
    always_ff @(posedge clk) begin
        if (rst)                               code <= RESET_CODE;
        else if (load && code_valid(load_code)) code <= load_code;
    end
endmodule

// File: rtl/addr_route.sv
module addr_route
    import progfetch_pkg::*;
(
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              ext_access_n,
    input  logic [CODE_W-1:0] code,
    output route_t            route
);
    logic [ADDR_W:0] limit;
    logic            beyond;

    always_comb begin
        limit     = code_limit(code);
        beyond    = ({1'b0, fetch_addr} >= limit) || !ext_access_n;
        route.rom = fetch_valid && !beyond;
        route.ext = fetch_valid && beyond;
    end
endmodule

// File: rtl/progfetch_router.sv
module progfetch_router
    import progfetch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_valid,
    input  logic [15:0] fetch_addr,
    input  logic        ext_access_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [7:0]  wr_data,
    output logic        rom_sel,
    output logic        ext_fetch,
    output logic        pstore_n
);
    reg_wr_t           wr;
    logic              win_open;
    logic              size_wr;
    logic [CODE_W-1:0] size_code;
    route_t            route;

    assign wr      = '{en: wr_en, sel: wr_sel, data: wr_data};
    assign size_wr = wr.en && wr.sel && win_open;

    ta_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (wr.en && !wr.sel),
        .key_data (wr.data),
        .consume  (size_wr),
        .win_open (win_open)
    );

    size_reg u_size (
        .clk       (clk),
        .rst       (rst),
        .load      (size_wr),
        .load_code (wr.data[CODE_W-1:0]),
        .code      (size_code)
    );

    addr_route u_route (
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr),
        .ext_access_n (ext_access_n),
        .code         (size_code),
        .route        (route)
    );

    assign rom_sel   = route.rom;
    assign ext_fetch = route.ext;
    assign pstore_n  = !route.ext;

endmodule

// File: rtl/progfetch_checker.sv
module progfetch_checker (
    input logic        clk,
    input logic        rst,
    input logic        fetch_valid,
    input logic [15:0] fetch_addr,
    input logic        ext_access_n,
    input logic        rom_sel,
    input logic        ext_fetch,
    input logic        pstore_n,
    input logic        win_open,
    input logic [2:0]  size_code
);
    assert_reset_code_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> size_code == 3'b101);

    assert_map_16k_R2: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && ext_access_n && size_code == 3'b101 && fetch_addr < 16'h4000) |-> rom_sel);

    assert_pin_override_R3: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !ext_access_n) |-> (ext_fetch && !rom_sel));

    assert_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !pstore_n |-> (fetch_valid && !rom_sel));

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(rom_sel && ext_fetch));

    assert_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (!win_open && !rst) |=> $stable(size_code));

    assert_no_reserved_R7: assert property (@(posedge clk) disable iff (rst)
        size_code <= 3'b101);
endmodule

bind progfetch_router progfetch_checker i_checker (
    .clk          (clk),
    .rst          (rst),
    .fetch_valid  (fetch_valid),
    .fetch_addr   (fetch_addr),
    .ext_access_n (ext_access_n),
    .rom_sel      (rom_sel),
    .ext_fetch    (ext_fetch),
    .pstore_n     (pstore_n),
    .win_open     (win_open),
    .size_code    (size_code)
);

// File: tb/test_progfetch_router.sv
`timescale 1ns/1ps
module test_progfetch_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_valid;
    logic [15:0] fetch_addr;
    logic        ext_access_n;
    logic        wr_en;
    logic        wr_sel;
    logic [7:0]  wr_data;
    logic        rom_sel;
    logic        ext_fetch;
    logic        pstore_n;

    typedef struct {
        logic        rom;
        logic        ext;
        logic        psn;
        logic [15:0] addr;
        string       req;
    } exp_t;

    exp_t q[$];
    event ev_sample;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    progfetch_router i_progfetch_router (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .ext_access_n(ext_access_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rom_sel(rom_sel), .ext_fetch(ext_fetch), .pstore_n(pstore_n)
    );

    function automatic int lim_of(input int code);
        case (code)
            0: return 0;
            1: return 1024;
            2: return 2048;
            3: return 4096;
            4: return 8192;
            default: return 16384;
        endcase
    endfunction

    // driver: presents a fetch and queues the expected routing
    task automatic fetch(input int a, input logic pin, input logic v, input int code, input string req);
        exp_t e;
        logic ext;
        fetch_addr   = 16'(a);
        ext_access_n = pin;
        fetch_valid  = v;
        ext   = (a >= lim_of(code)) || !pin;
        e.rom = v && !ext;
        e.ext = v && ext;
        e.psn = !(v && ext);
        e.addr = 16'(a);
        e.req  = req;
        q.push_back(e);
        -> ev_sample;
        #2;
    endtask

    // monitor: pops expected items and compares
    initial begin
        forever begin
            exp_t e;
            @(ev_sample);
            #1;
            e = q.pop_front();
            n_checks++;
            if (rom_sel !== e.rom || ext_fetch !== e.ext || pstore_n !== e.psn) begin
                n_fail++;
                $display("FAIL %s addr=%h actual rom=%b ext=%b psn=%b expected rom=%b ext=%b psn=%b",
                         e.req, e.addr, rom_sel, ext_fetch, pstore_n, e.rom, e.ext, e.psn);
            end
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic unlock();
        wr(1'b0, 8'hAA);
        wr(1'b0, 8'h55);
    endtask

    task automatic set_code(input int c);
        unlock();
        wr(1'b1, 8'(c));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        fetch_valid = 1'b0; fetch_addr = '0; ext_access_n = 1'b1;
        @(negedge clk);
        idle(2);
        rst = 1'b0;
        idle(1);

        // R1: reset code selects 16KB
        fetch(16'h3FFF, 1'b1, 1'b1, 5, "R1");
        fetch(16'h4000, 1'b1, 1'b1, 5, "R1");

        // R4: no valid fetch -> all idle
        fetch(16'h8000, 1'b1, 1'b0, 5, "R4");
        fetch(16'h0000, 1'b0, 1'b0, 5, "R4");

        // R2 / R3 / R8: boundary sweep for every valid code
        for (int c = 0; c <= 5; c++) begin
            set_code(c);
            if (lim_of(c) > 0) begin
                fetch(lim_of(c) - 1, 1'b1, 1'b1, c, "R8");
                fetch(lim_of(c) - 1, 1'b0, 1'b1, c, "R3");
            end
            fetch(lim_of(c), 1'b1, 1'b1, c, "R2");
            fetch(lim_of(c), 1'b0, 1'b1, c, "R3");
            fetch(0, 1'b1, 1'b1, c, "R2");
            fetch(16'hFFFF, 1'b1, 1'b1, c, "R2");
            fetch(0, 1'b0, 1'b1, c, "R3");
        end

        // R5: write without unlock ignored (code stays 5)
        wr(1'b1, 8'd3);
        fetch(16'h1000, 1'b1, 1'b1, 5, "R5");

        // R7: reserved codes ignored
        set_code(6);
        fetch(16'h3FFF, 1'b1, 1'b1, 5, "R7");
        set_code(7);
        fetch(16'h3FFF, 1'b1, 1'b1, 5, "R7");

        // R6: write on 4th window cycle accepted
        unlock(); idle(3); wr(1'b1, 8'd3);
        fetch(16'h0FFF, 1'b1, 1'b1, 3, "R6");
        fetch(16'h1000, 1'b1, 1'b1, 3, "R6");

        // R6: write on 5th window cycle ignored
        unlock(); idle(4); wr(1'b1, 8'd1);
        fetch(16'h0400, 1'b1, 1'b1, 3, "R6");

        // R6: second key 4 cycles after first does not unlock
        wr(1'b0, 8'hAA); idle(3); wr(1'b0, 8'h55); wr(1'b1, 8'd1);
        fetch(16'h0400, 1'b1, 1'b1, 3, "R6");

        // R6: second key 3 cycles after first unlocks
        wr(1'b0, 8'hAA); idle(2); wr(1'b0, 8'h55); wr(1'b1, 8'd4);
        fetch(16'h1FFF, 1'b1, 1'b1, 4, "R6");

        // R9: one write per unlock
        unlock(); wr(1'b1, 8'd2); wr(1'b1, 8'd5);
        fetch(16'h0800, 1'b1, 1'b1, 2, "R9");
        fetch(16'h07FF, 1'b1, 1'b1, 2, "R9");

        // R10: reset closes window
        unlock(); do_reset(); wr(1'b1, 8'd0);
        fetch(16'h0000, 1'b1, 1'b1, 5, "R10");
        fetch(16'h3FFF, 1'b1, 1'b1, 5, "R1");

        idle(2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule